// File: doc/BRIEF.md
# Interrupt Enable Controller with Master Gate

This block decides whether a small processor core should take an interrupt, and which source it should take. It serves up to 24 sources, which form three banks of eight. Each source has its own request flag and its own enable bit. A source pulse sets the request flag. The flag stays set until the core takes that source's vector or until software clears it. A single master enable gates every request.

When the core takes a vector, the block clears the master enable, so a second interrupt cannot nest on top of the first. The return-from-interrupt strobe sets the master enable again. Software reaches every enable bit, every flag bit and the master bit through single-bit set and clear writes. Each write touches exactly one bit and leaves its neighbours in the same bank alone. The block does not form vector addresses and does not handle the stack.

Top module: `irq_gate_ctrl`

## Requirements
- R1: A bit write (`bit_we`=1) changes only the one addressed bit. `bit_sel` 0..2 selects enable bank k, which covers sources 8k..8k+7, and `bit_pos` picks the source inside the bank. `bit_sel` 3..5 selects request-flag bank k in the same way. `bit_sel` 6 with `bit_pos` 0 selects the master enable. `bit_val` is the new value of the bit. Every other address has no effect.
- R2: A one-cycle pulse on `src_pulse[i]` sets flag i, whatever the enable bits hold. The flag stays set until the core acknowledges source i or software writes it to 0.
- R3: `irq_req` is high exactly when the master enable is 1 and at least one source has both its flag and its enable bit set. A pending source whose enable bit is 0 never raises `irq_req`.
- R4: `vec_ack` while `irq_req` is high clears the master enable at the next edge. `vec_ack` while `irq_req` is low has no effect at all.
- R5: `reti` sets the master enable at the next edge.
- R6: An accepted `vec_ack` clears only the flag of the source shown on `irq_idx`. Every other pending flag stays set.
- R7: When several enabled sources are pending, `irq_idx` shows the lowest index among them. With no enabled source pending, `irq_idx` is 0.
- R8: A request that arrives while the master enable is 0 stays pending. It raises `irq_req` once `reti` sets the master enable.
- R9: After a synchronous reset, all enables, all flags and the master enable are 0. `irq_req` and `irq_idx` are then 0.
- R10: When two updates land on the same bit in one cycle, these rules decide:
  - A source pulse wins over a clear of its flag, whether the clear comes from software or from an acknowledge.
  - An acknowledge wins over `reti` and over a software write of the master bit.
  - `reti` wins over a software write of the master bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 24 | One request pulse per source |
| bit_we | input | 1 | Single-bit software write strobe |
| bit_sel | input | 3 | Register select for the bit write |
| bit_pos | input | 3 | Bit position inside the selected register |
| bit_val | input | 1 | Value written to the selected bit |
| vec_ack | input | 1 | Core takes the vector of the current winner |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 5 | Index of the winning source |
| master_en | output | 1 | Current master enable |

## Verification
The bench builds the block with its default shape: three banks of eight, 24 sources in all. At that size every source can be taken alone through raise, acknowledge and return. Every ordered pair of sources can also be raised in the same cycle, so the lowest-index rule and the rule that an acknowledge clears only the winner are both checked across the whole index range. Directed steps then cover bit isolation inside a bank, requests that wait while the master is off, ignored writes and acknowledges, and the same-cycle collisions.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NREG   = 3;
    localparam int REG_W  = 8;
    localparam int NSRC   = NREG * REG_W;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int POS_W  = $clog2(REG_W);
    localparam int SEL_W  = $clog2(2 * NREG + 1);
    localparam int SEL_MASTER = 2 * NREG;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ENABLE,
        TGT_FLAG,
        TGT_MASTER
    } wr_target_e;

    typedef struct packed {
        wr_target_e        tgt;
        logic [NSRC-1:0]   mask;
        logic              val;
    } bit_wr_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic bit_wr_t decode_wr(input logic we, input logic [SEL_W-1:0] sel,
                                          input logic [POS_W-1:0] pos, input logic val);
        bit_wr_t r;
        int unsigned bank;
        r.tgt  = TGT_NONE;
        r.mask = '0;
        r.val  = val;
        bank   = 0;
        if (we) begin
            if (int'(sel) < NREG) begin
                r.tgt = TGT_ENABLE;
                bank  = int'(sel);
            end else if (int'(sel) < 2 * NREG) begin
                r.tgt = TGT_FLAG;
                bank  = int'(sel) - NREG;
            end else if (int'(sel) == SEL_MASTER && pos == '0) begin
                r.tgt = TGT_MASTER;
            end
            if (r.tgt == TGT_ENABLE || r.tgt == TGT_FLAG)
                r.mask[bank * REG_W + int'(pos)] = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bit_wr_t         wr,
    input  logic            ack_fire,
    input  logic            reti,
    output logic [NSRC-1:0] en_q,
    output logic            master_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            master_q <= 1'b0;
        end else begin
            if (wr.tgt == TGT_ENABLE)
                en_q <= wr.val ? (en_q | wr.mask) : (en_q & ~wr.mask);
            if (ack_fire)
                master_q <= 1'b0;
            else if (reti)
                master_q <= 1'b1;
            else if (wr.tgt == TGT_MASTER)
                master_q <= wr.val;
        end
    end

    a_r4_ack_drops_master: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> !master_q);
    a_r5_reti_raises_master: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack_fire) |=> master_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  pulse,
    input  bit_wr_t          wr,
    input  logic             ack_fire,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [NSRC-1:0]  flag_q
);
    logic [NSRC-1:0] hw_clr, sw_clr, sw_set, clr_all;

    always_comb begin
        hw_clr = '0;
        if (ack_fire)
            hw_clr[ack_idx] = 1'b1;
        sw_clr  = (wr.tgt == TGT_FLAG && !wr.val) ? wr.mask : '0;
        sw_set  = (wr.tgt == TGT_FLAG &&  wr.val) ? wr.mask : '0;
        clr_all = hw_clr | sw_clr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~clr_all) | sw_set | pulse;
    end

    a_r2_flag_holds: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(flag_q & ~clr_all)) == $past(flag_q & ~clr_all)));
    a_r2_pulse_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(pulse)) == $past(pulse)));
    a_r6_ack_clears_winner: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && pulse[ack_idx] == 1'b0 && sw_set[ack_idx] == 1'b0)
        |=> flag_q[$past(ack_idx)] == 1'b0);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output pick_t           pick
);
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick.hit = 1'b1;
                pick.idx = IDX_W'(i);
            end
        end
    end

    a_r7_lowest_wins: assert final (!pick.hit ||
        (pend[pick.idx] && ((pend & ((NSRC'(1) << pick.idx) - NSRC'(1))) == '0)));
    a_r7_idle_zero: assert final (pick.hit || (pick.idx == '0 && pend == '0));
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_pulse,
    input  logic             bit_we,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             bit_val,
    input  logic             vec_ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [IDX_W-1:0] irq_idx,
    output logic             master_en
);
    bit_wr_t         wr;
    logic [NSRC-1:0] en_q, flag_q;
    logic            master_q, ack_fire;
    pick_t           pick;

    assign wr       = decode_wr(bit_we, bit_sel, bit_pos, bit_val);
    assign irq_req  = master_q & pick.hit;
    assign irq_idx  = pick.idx;
    assign master_en = master_q;
    assign ack_fire = vec_ack & irq_req;

    irq_enable_regs u_en (
        .clk(clk), .rst(rst), .wr(wr), .ack_fire(ack_fire), .reti(reti),
        .en_q(en_q), .master_q(master_q)
    );

    irq_flag_bank u_flag (
        .clk(clk), .rst(rst), .pulse(src_pulse), .wr(wr), .ack_fire(ack_fire),
        .ack_idx(pick.idx), .flag_q(flag_q)
    );

    irq_prio_pick u_pick (.pend(flag_q & en_q), .pick(pick));

    a_r3_master_gates: assert property (@(posedge clk) disable iff (rst)
        !master_q |-> !irq_req);
    a_r3_req_needs_enabled_flag: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (flag_q[irq_idx] && en_q[irq_idx]));
    a_r4_ignored_ack: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && !irq_req && !reti && !(bit_we && bit_sel == SEL_W'(SEL_MASTER)))
        |=> master_q == $past(master_q));
endmodule

// File: tb/sim_irq_gate_ctrl.sv
`timescale 1ns/1ps
module sim_irq_gate_ctrl;
    import irq_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic [NSRC-1:0] src_pulse;
    logic bit_we, bit_val, vec_ack, reti;
    logic [SEL_W-1:0] bit_sel;
    logic [POS_W-1:0] bit_pos;
    logic irq_req, master_en;
    logic [IDX_W-1:0] irq_idx;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_gate_ctrl u0 (.clk(clk), .rst(rst), .src_pulse(src_pulse), .bit_we(bit_we),
        .bit_sel(bit_sel), .bit_pos(bit_pos), .bit_val(bit_val), .vec_ack(vec_ack),
        .reti(reti), .irq_req(irq_req), .irq_idx(irq_idx), .master_en(master_en));

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        src_pulse = '0; bit_we = 0; vec_ack = 0; reti = 0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wbit(input int sel, input int pos, input logic v);
        bit_we = 1; bit_sel = SEL_W'(sel); bit_pos = POS_W'(pos); bit_val = v;
        tick();
    endtask

    task automatic set_en(input int s, input logic v);
        wbit(s / REG_W, s % REG_W, v);
    endtask

    task automatic set_flag(input int s, input logic v);
        wbit(NREG + s / REG_W, s % REG_W, v);
    endtask

    task automatic clear_all();
        for (int s = 0; s < NSRC; s++) begin
            set_en(s, 0);
            set_flag(s, 0);
        end
    endtask

    task automatic pulse(input int s);
        src_pulse[s] = 1'b1;
        tick();
    endtask

    task automatic do_ack();
        vec_ack = 1; tick();
    endtask

    task automatic do_reti();
        reti = 1; tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        src_pulse = '0; bit_we = 0; bit_sel = '0; bit_pos = '0; bit_val = 0;
        vec_ack = 0; reti = 0; rst = 1;
        @(negedge clk); tick(); tick();
        rst = 0;
        // R9 reset state
        chk("R9 irq_req", irq_req, 0);
        chk("R9 irq_idx", irq_idx, 0);
        chk("R9 master_en", master_en, 0);
        do_reti();
        chk("R9 no flag after reset", irq_req, 0);

        // R2 / R3: pulse latches while disabled, raises once enabled
        pulse(5);
        chk("R3 disabled pending", irq_req, 0);
        set_en(5, 1);
        chk("R2 latched while disabled", irq_req, 1);
        chk("R2 idx", irq_idx, 5);
        set_en(5, 0);
        set_flag(5, 0);

        // single-source sweep: R1 R4 R5 R6
        for (int i = 0; i < NSRC; i++) begin
            set_en(i, 1);
            pulse(i);
            chk("R7 single idx", irq_idx, i);
            chk("R3 single req", irq_req, 1);
            do_ack();
            chk("R4 master cleared", master_en, 0);
            chk("R4 req dropped", irq_req, 0);
            do_reti();
            chk("R5 master set", master_en, 1);
            chk("R6 flag cleared", irq_req, 0);
            set_en(i, 0);
        end

        // pair sweep: R7 R6 R8
        for (int i = 0; i < NSRC; i++) begin
            for (int j = i + 1; j < NSRC; j++) begin
                set_en(i, 1); set_en(j, 1);
                src_pulse[i] = 1; src_pulse[j] = 1; tick();
                chk("R7 pair winner", irq_idx, i);
                do_ack();
                chk("R4 pair master", master_en, 0);
                do_reti();
                chk("R6 loser kept", irq_req, 1);
                chk("R8 loser idx", irq_idx, j);
                do_ack(); do_reti();
                chk("R6 both served", irq_req, 0);
                set_en(i, 0); set_en(j, 0);
            end
        end

        // R1 bit isolation
        for (int s = 0; s < NSRC; s++) set_en(s, 1);
        set_en(13, 0);
        src_pulse[13] = 1; src_pulse[20] = 1; tick();
        chk("R1 cleared bit only", irq_idx, 20);
        set_en(12, 0);
        chk("R1 neighbour write", irq_idx, 20);
        set_en(13, 1);
        chk("R1 reenable", irq_idx, 13);
        wbit(7, 0, 0);
        wbit(SEL_MASTER, 3, 0);
        chk("R1 invalid address ignored", irq_req, 1);
        chk("R1 invalid master pos", master_en, 1);
        wbit(SEL_MASTER, 0, 0);
        chk("R1 master write", irq_req, 0);
        clear_all();

        // R8 request waits while master off
        set_en(3, 1);
        pulse(3);
        chk("R8 held off", irq_req, 0);
        do_ack();
        chk("R4 ack ignored master", master_en, 0);
        do_reti();
        chk("R8 served after reti", irq_req, 1);
        chk("R8 idx", irq_idx, 3);

        // R2 software clear
        set_flag(3, 0);
        chk("R2 sw clear", irq_req, 0);

        // R10 pulse beats sw clear
        bit_we = 1; bit_sel = SEL_W'(NREG); bit_pos = 3; bit_val = 0; src_pulse[3] = 1;
        tick();
        chk("R10 pulse over clear", irq_req, 1);
        // R10 ack beats reti
        vec_ack = 1; reti = 1; tick();
        chk("R10 ack over reti", master_en, 0);
        do_reti();
        set_en(4, 1); pulse(4);
        // R10 ack beats master write, and pulse beats ack clear
        vec_ack = 1; src_pulse[4] = 1;
        bit_we = 1; bit_sel = SEL_W'(SEL_MASTER); bit_pos = 0; bit_val = 1; tick();
        chk("R10 ack over sw master", master_en, 0);
        // R10 reti beats sw master clear
        reti = 1; bit_we = 1; bit_sel = SEL_W'(SEL_MASTER); bit_pos = 0; bit_val = 0; tick();
        chk("R10 reti over sw write", master_en, 1);
        chk("R10 pulse over ack clear", irq_idx, 4);

        // R9 reset again
        rst = 1; tick(); rst = 0;
        chk("R9 second reset req", irq_req, 0);
        chk("R9 second reset master", master_en, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule